// File: doc/BRIEF.md
# Adjustable Dead-Time Inserter for Three Complementary Switch Pairs

This block sits between three PWM comparators and the gate drivers of a three-phase AC voltage regulator. Each phase has a shunt (freewheeling) switch and a series switch. The comparator bit drives the shunt switch, and its complement drives the series switch. The block creates both halves of every pair. It lets a turn-off pass on the next clock edge, but it holds back every turn-on until the source has stayed asserted for a programmed time. This opens a gap in which neither switch of a pair conducts, so the supply is never shorted through a pair during a change-over.

The gap is timed in ticks. Each signal has its own prescaler, and the prescaler restarts whenever that signal's source drops. A turn-on waits for a fixed number of ticks, and each tick lasts a programmable number of clock cycles. Two push-button inputs raise or lower the tick length while the block runs. The block synchronises each button and acts once per press. The current tick length leaves the block as a binary word for a separate display block. All six gate outputs are inverted, so a driver stage built on inverting optocouplers sees a conducting switch as a low level.

Top module: `deadband_gate`

## Requirements
- R1: While `rst_n` is low, all six drive outputs are 1 (switch off) and `period_val` equals `DIV_INIT`.
- R2: `shunt_drv_n[p]` goes to 0 (switch on) on the clock edge at which `pwm_in[p]` has been sampled as 1 on `N_TICKS*period_val` consecutive edges, counting the first edge that sees the 1 as edge one.
- R3: `series_drv_n[p]` follows the same rule while `pwm_in[p]` is sampled as 0.
- R4: A drive output returns to 1 on the first clock edge at which its source is no longer asserted.
- R5: A source that stays asserted for fewer than `N_TICKS*period_val` consecutive edges produces no 0 on its drive output. The count starts again from zero on the next assertion.
- R6: A rising edge on `btn_longer` raises `period_val` by exactly one, once per press however long the button is held. The new value is visible by the third clock edge after the press is sampled.
- R7: A rising edge on `btn_shorter` lowers `period_val` by exactly one, once per press.
- R8: `period_val` never leaves the range 1 to `DIV_MAX`. Presses beyond either end leave it unchanged.
- R9: A changed `period_val` sets the turn-on delay of every later assertion, as R2 and R3 describe.
- R10: In every clock cycle, `shunt_drv_n[p]` and `series_drv_n[p]` are never both 0 at the same time.
- R11: When both buttons rise in the same sampled cycle, `period_val` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_in | input | NPAIR | One comparator bit per phase: 1 requests the shunt switch, 0 requests the series switch |
| btn_longer | input | 1 | Asynchronous push button that lengthens the tick |
| btn_shorter | input | 1 | Asynchronous push button that shortens the tick |
| shunt_drv_n | output | NPAIR | Inverted shunt-switch gate drive, 0 means conducting |
| series_drv_n | output | NPAIR | Inverted series-switch gate drive, 0 means conducting |
| period_val | output | DIV_W | Current tick length in clock cycles, for display |

## Verification
The bench builds the block with `N_TICKS=3`, `DIV_INIT=2`, `DIV_MAX=6` and `DIV_W=4`. With these values the full turn-on delay lies between 3 and 18 cycles. A handful of presses therefore drives the tick length into both clamps, and the bench measures the dead time at the bottom, middle and top of the range within a few hundred cycles. The pulse patterns include assertions one edge shorter than the delay and mixed per-phase patterns. Each phase is then checked cycle by cycle for exact turn-on timing, immediate turn-off and pair exclusivity.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  // Action requested of the tick-length register in one cycle.
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_cmd_e;

endpackage

// File: rtl/db_reset_sync.sv
module db_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] stage_q;

  // Asserts at once, and releases two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_core_n = stage_q[1];

endmodule

// File: rtl/db_button_in.sv
module db_button_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic press
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], btn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  // A single-cycle pulse on the synchronised rising edge.
  assign press = sync_q[STAGES-1] & ~prev_q;

  // R6: a held button yields one pulse, never two in a row
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);

endmodule

// File: rtl/db_period_reg.sv
module db_period_reg
  import deadband_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DIV_MAX  = 50000,
  parameter int DIV_INIT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_pulse,
  input  logic             down_pulse,
  output logic [DIV_W-1:0] period
);

  localparam logic [DIV_W-1:0] P_MAX  = DIV_W'(DIV_MAX);
  localparam logic [DIV_W-1:0] P_MIN  = DIV_W'(1);
  localparam logic [DIV_W-1:0] P_INIT = DIV_W'(DIV_INIT);

  adj_cmd_e         cmd;
  logic [DIV_W-1:0] per_q;
  logic [DIV_W-1:0] per_d;
  logic             per_en;

  always_comb begin
    unique case ({up_pulse, down_pulse})
      2'b10:   cmd = ADJ_UP;
      2'b01:   cmd = ADJ_DOWN;
      default: cmd = ADJ_HOLD;
    endcase
  end

  always_comb begin
    per_d  = per_q;
    per_en = 1'b0;
    case (cmd)
      ADJ_UP: begin
        if (per_q < P_MAX) begin
          per_d  = per_q + P_MIN;
          per_en = 1'b1;
        end
      end
      ADJ_DOWN: begin
        if (per_q > P_MIN) begin
          per_d  = per_q - P_MIN;
          per_en = 1'b1;
        end
      end
      default: begin
        per_d  = per_q;
        per_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= P_INIT;
    end else if (per_en) begin
      per_q <= per_d;
    end
  end

  assign period = per_q;

  // R8: the tick length stays inside its clamps
  p_period_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= P_MIN) && (per_q <= P_MAX));

  // R6: a lone up press below the top raises the value by one
  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && !down_pulse && per_q < P_MAX) |=> per_q == $past(per_q) + P_MIN);

  // R7: a lone down press above the bottom lowers the value by one
  p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (down_pulse && !up_pulse && per_q > P_MIN) |=> per_q == $past(per_q) - P_MIN);

  // R11: simultaneous presses leave the value alone
  p_both_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && down_pulse) |=> $stable(per_q));

endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay #(
  parameter int DIV_W   = 16,
  parameter int N_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [DIV_W-1:0] period,
  output logic             active
);

  localparam int              TW        = $clog2(N_TICKS + 1);
  localparam logic [TW-1:0]   LAST_TICK = TW'(N_TICKS - 1);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;
  logic [TW-1:0]    tk_q;
  logic [TW-1:0]    tk_d;
  logic             on_q;
  logic             on_d;
  logic             tick;
  logic             upd_en;

  // The >= comparison keeps a shortened period from running the prescaler past it.
  always_comb begin
    tick   = (pre_q >= (period - ONE));
    pre_d  = pre_q;
    tk_d   = tk_q;
    on_d   = on_q;
    upd_en = !(raw && on_q);
    if (!raw) begin
      pre_d = '0;
      tk_d  = '0;
      on_d  = 1'b0;
    end else if (!on_q) begin
      if (tick) begin
        pre_d = '0;
        if (tk_q == LAST_TICK) begin
          tk_d = '0;
          on_d = 1'b1;
        end else begin
          tk_d = tk_q + TW'(1);
        end
      end else begin
        pre_d = pre_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tk_q  <= '0;
      on_q  <= 1'b0;
    end else if (upd_en) begin
      pre_q <= pre_d;
      tk_q  <= tk_d;
      on_q  <= on_d;
    end
  end

  assign active = on_q;

  // R4: a dropped source switches the gate off on the next edge
  p_drop_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !active);

  // R5: a turn-on only follows an edge on which the source was high
  p_on_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(raw));

endmodule

// File: rtl/deadband_gate.sv
module deadband_gate #(
  parameter int NPAIR       = 3,
  parameter int DIV_W       = 16,
  parameter int DIV_MAX     = 50000,
  parameter int DIV_INIT    = 50,
  parameter int N_TICKS     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] pwm_in,
  input  logic             btn_longer,
  input  logic             btn_shorter,
  output logic [NPAIR-1:0] shunt_drv_n,
  output logic [NPAIR-1:0] series_drv_n,
  output logic [DIV_W-1:0] period_val
);

  logic             rst_core_n;
  logic             up_pulse;
  logic             down_pulse;
  logic [DIV_W-1:0] period;
  logic [NPAIR-1:0] shunt_on;
  logic [NPAIR-1:0] series_on;

  db_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  db_button_in #(.STAGES(SYNC_STAGES)) u_btn_up (
    .clk   (clk),
    .rst_n (rst_core_n),
    .btn   (btn_longer),
    .press (up_pulse)
  );

  db_button_in #(.STAGES(SYNC_STAGES)) u_btn_dn (
    .clk   (clk),
    .rst_n (rst_core_n),
    .btn   (btn_shorter),
    .press (down_pulse)
  );

  db_period_reg #(
    .DIV_W    (DIV_W),
    .DIV_MAX  (DIV_MAX),
    .DIV_INIT (DIV_INIT)
  ) u_period (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .up_pulse   (up_pulse),
    .down_pulse (down_pulse),
    .period     (period)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    db_edge_delay #(.DIV_W(DIV_W), .N_TICKS(N_TICKS)) u_shunt (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .raw    (pwm_in[p]),
      .period (period),
      .active (shunt_on[p])
    );

    db_edge_delay #(.DIV_W(DIV_W), .N_TICKS(N_TICKS)) u_series (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .raw    (~pwm_in[p]),
      .period (period),
      .active (series_on[p])
    );

    // R10: both switches of one phase never conduct together
    p_pair_excl_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
      !(shunt_on[p] && series_on[p]));
  end

  // Inverting output stage for optocoupler-driven gates.
  assign shunt_drv_n  = ~shunt_on;
  assign series_drv_n = ~series_on;
  assign period_val   = period;

endmodule

// File: tb/deadband_gate_bench.sv
module deadband_gate_bench;

  localparam int NP    = 3;
  localparam int DW    = 4;
  localparam int DMAX  = 6;
  localparam int DINIT = 2;
  localparam int NT    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pwm = '0;
  logic          b_up = 1'b0;
  logic          b_dn = 1'b0;
  logic [NP-1:0] sh_n;
  logic [NP-1:0] se_n;
  logic [DW-1:0] per;

  always #2.5 clk = ~clk;

  deadband_gate #(
    .NPAIR(NP), .DIV_W(DW), .DIV_MAX(DMAX), .DIV_INIT(DINIT),
    .N_TICKS(NT), .SYNC_STAGES(2)
  ) u_deadband_gate (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .btn_longer(b_up),
    .btn_shorter(b_dn), .shunt_drv_n(sh_n), .series_drv_n(se_n),
    .period_val(per)
  );

  typedef struct {
    int            cyc;
    logic [NP-1:0] sh;
    logic [NP-1:0] se;
    string         tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_div = DINIT;
  int    run_hi[NP];
  int    run_lo[NP];
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected items as their cycle is reached.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        item_t it;
        it = sb.pop_front();
        if (it.cyc == cyc) begin
          check({it.tag, " shunt"}, 32'(sh_n), 32'(it.sh));
          check({it.tag, " series"}, 32'(se_n), 32'(it.se));
        end else begin
          n_chk++;
          n_fail++;
          $display("FAIL %s: actual cycle %0d expected cycle %0d", it.tag, cyc, it.cyc);
        end
      end
      for (int p = 0; p < NP; p++)
        check("R10 pair exclusive", 32'(!sh_n[p] && !se_n[p]), 32'd0);
    end
  end

  // Driver: applies a pattern and pushes the expected outputs of each edge.
  task automatic apply(input logic [NP-1:0] v, input int n, input string tag);
    item_t it;
    int    base;
    @(negedge clk);
    pwm  = v;
    base = cyc;
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < NP; p++) begin
        run_hi[p] = v[p] ? run_hi[p] + 1 : 0;
        run_lo[p] = v[p] ? 0 : run_lo[p] + 1;
        it.sh[p]  = !(run_hi[p] >= NT * exp_div);
        it.se[p]  = !(run_lo[p] >= NT * exp_div);
      end
      it.cyc = base + 1 + k;
      it.tag = tag;
      sb.push_back(it);
    end
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic press(input logic up, input logic dn, input int hold, input string tag);
    apply(pwm, NT * DMAX + 2, {tag, " settle"});
    @(negedge clk);
    b_up = up;
    b_dn = dn;
    apply(pwm, hold, {tag, " held"});
    b_up = 1'b0;
    b_dn = 1'b0;
    apply(pwm, 6, {tag, " released"});
    if (up && !dn && exp_div < DMAX) exp_div++;
    if (dn && !up && exp_div > 1) exp_div--;
    check({tag, " period"}, 32'(per), 32'(exp_div));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset shunt", 32'(sh_n), 32'(3'b111));
    check("R1 reset series", 32'(se_n), 32'(3'b111));
    check("R1 reset period", 32'(per), 32'(DINIT));
    rst_n = 1'b1;
    repeat (NT * DMAX + 6) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      run_lo[p] = 1000;
      run_hi[p] = 0;
    end
    check("R3 series settled", 32'(se_n), 32'd0);
    check("R2 shunt idle", 32'(sh_n), 32'(3'b111));

    apply(3'b111, 10, "R2 R4 all rise");
    apply(3'b000, 10, "R3 R4 all fall");
    apply(3'b101, 5, "R5 short high");
    apply(3'b000, 8, "R5 after short high");
    apply(3'b010, 5, "R5 short low");
    apply(3'b000, 8, "R3 recover");
    apply(3'b011, 7, "R2 R3 mixed a");
    apply(3'b110, 9, "R2 R3 mixed b");

    press(1'b1, 1'b0, 3, "R6 single press");
    apply(3'b001, 12, "R9 longer gap a");
    apply(3'b110, 12, "R9 longer gap b");
    apply(3'b111, 8, "R5 R9 below new delay");
    apply(3'b000, 12, "R9 fall longer");

    press(1'b1, 1'b0, 25, "R6 long hold");
    for (int i = 0; i < 4; i++) press(1'b1, 1'b0, 3, "R8 toward top");
    check("R8 top clamp", 32'(per), 32'(DMAX));
    apply(3'b100, 20, "R9 top delay");
    apply(3'b011, 20, "R9 top delay swap");

    press(1'b1, 1'b1, 3, "R11 both buttons");
    check("R11 unchanged", 32'(per), 32'(DMAX));

    press(1'b0, 1'b1, 3, "R7 single down");
    for (int i = 0; i < 6; i++) press(1'b0, 1'b1, 3, "R8 toward bottom");
    check("R8 bottom clamp", 32'(per), 32'd1);

    apply(3'b101, 4, "R9 short delay");
    apply(3'b010, 5, "R9 short delay swap");
    apply(3'b111, 2, "R5 one below minimum");
    apply(3'b000, 6, "R4 minimum fall");
    apply(3'b111, 3, "R2 exact minimum");
    apply(3'b000, 6, "R3 exact minimum");

    repeat (3) @(negedge clk);
    done = 1'b1;
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard (R2): actual %0d left expected 0", sb.size());
    end
    summary();
    $finish;
  end

endmodule